// File: doc/BRIEF.md
# System configuration register controller

A 4 KiB memory-mapped block of 32-bit control and status registers on a simple register bus. Writes are accepted when `req_i` and `we_i` are high at a rising clock edge. Read data is presented combinationally for the address on the bus while a read request is high. The block holds two general configuration words, and the low byte of the second word drives eight LED outputs. It also returns fixed identification words that are set at build time.

An indirect configuration channel reaches a small bank of oscillator-frequency registers. Software loads an outgoing data word, then writes a command word. The command carries a device number, a function code, a direction flag and a start flag. The transaction finishes in the cycle the command is accepted. Done and error flags appear in a status word, and a read result appears in a return-data word.

A lock register combines eight per-loop lock flags under a writable mask. Accesses to unmapped offsets, and writes to read-only offsets, raise a one-cycle error pulse.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, the registers read as follows: channel command 0x00100000, lock register 0xFFFF0001 (with all lock flags high), every other writable register 0, and `led_o` 0. The oscillators reset to 50000000, 24576000 and 25000000 for devices 0, 1 and 2.
- R2: Configuration word 0 (offset 0x000) and configuration word 1 (offset 0x004) store all 32 written bits. Bits [7:0] of word 1 appear on `led_o` from the cycle after the write.
- R3: Offset 0x00C always reads 0. Offsets 0x010, 0xFF8 and 0xFFC read the build-time values `CFG4_VAL`, `AUX_ID` and `BLK_ID`. Writes to these four offsets do not change what they read.
- R4: The channel command (offset 0x0A8) holds the device number in [11:0], the function code in [25:20] and the write flag in bit 30. Bits [19:12], [29:26] and the start bit 31 are stored as zero.
- R5: Every write to the channel command clears the channel status (offset 0x0AC), so a command written without start leaves the status at 0.
- R6: A command written with start sets status bit 0 (done). It also sets status bit 1 (error) unless the function code is 1 and the device number is below 3.
- R7: A valid write command copies the out-data word (offset 0x0A4) into the selected oscillator. A valid read command loads the selected oscillator into return-data (offset 0x0A0).
- R8: A failed read leaves return-data unchanged, and a failed write changes no oscillator.
- R9: In the lock register (offset 0x100), only the mask [31:24] is writable. Bits [23:16] show `lock_flags_i`, bits [15:1] read 0, and bit 0 is 1 exactly when every flag selected by the mask is 1.
- R10: Reads of unmapped offsets return 0, and writes to unmapped offsets change nothing. An unmapped access, or a write to a read-only offset (0x00C, 0x010, 0x0A0, 0x0AC, 0xFF8, 0xFFC), makes `bad_access_o` high for exactly the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset in the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| lock_flags_i | input | 8 | Per-loop lock flags |
| led_o | output | 8 | LED drive from configuration word 1 |
| bad_access_o | output | 1 | One-cycle pulse after a bad access |

## Verification
The assertions assume that the bus stays idle while reset is held, and that `lock_flags_i` changes only away from clock edges. The assertions relate each command or mask write to the register state one cycle later. The stimulus drives every bus signal, and the flags, a short delay after a rising edge, and drops the request for at least one cycle between accesses. As a result, each access and each error pulse can be attributed to a single cycle.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int NLOOP = 8;

  localparam logic [AW-1:0] OFF_CFG0 = 12'h000;
  localparam logic [AW-1:0] OFF_CFG1 = 12'h004;
  localparam logic [AW-1:0] OFF_CFG3 = 12'h00C;
  localparam logic [AW-1:0] OFF_CFG4 = 12'h010;
  localparam logic [AW-1:0] OFF_RTN  = 12'h0A0;
  localparam logic [AW-1:0] OFF_OUT  = 12'h0A4;
  localparam logic [AW-1:0] OFF_CMD  = 12'h0A8;
  localparam logic [AW-1:0] OFF_STAT = 12'h0AC;
  localparam logic [AW-1:0] OFF_LOCK = 12'h100;
  localparam logic [AW-1:0] OFF_AUX  = 12'hFF8;
  localparam logic [AW-1:0] OFF_ID   = 12'hFFC;

  // command word field positions
  localparam int DEV_W   = 12;
  localparam int FUNC_LO = 20;
  localparam int FUNC_W  = 6;
  localparam int WR_BIT  = 30;
  localparam int GO_BIT  = 31;
  localparam logic [FUNC_W-1:0] FUNC_OSC = 6'd1;

  localparam logic [DW-1:0] CMD_KEEP =
    (DW'(1) << WR_BIT) | (((DW'(1) << FUNC_W) - 1) << FUNC_LO) | ((DW'(1) << DEV_W) - 1);
  localparam logic [DW-1:0] CMD_RST  = DW'(FUNC_OSC) << FUNC_LO;
  localparam logic [NLOOP-1:0] MASK_RST = '1;
endpackage

// File: rtl/sysctl_chan.sv
module sysctl_chan
  import sysctl_pkg::*;
#(
  parameter int N_OSC = 3,
  parameter logic [N_OSC-1:0][DW-1:0] OSC_RST = {32'd25000000, 32'd24576000, 32'd50000000}
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_we_i,
  input  logic          out_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cmd_o,
  output logic [1:0]    stat_o,
  output logic [DW-1:0] out_o,
  output logic [DW-1:0] rtn_o
);
  localparam int IW = (N_OSC > 1) ? $clog2(N_OSC) : 1;

  logic [DW-1:0] cmd_q, out_q, rtn_q;
  logic [1:0]    stat_q;
  logic [DW-1:0] osc_q [N_OSC];
  logic [DEV_W-1:0]  dev_w;
  logic [FUNC_W-1:0] func_w;
  logic go_w, wr_w, ok_w;
  logic [IW-1:0] idx_w;
  logic [DW-1:0] sel_osc;

  assign dev_w  = wdata_i[DEV_W-1:0];
  assign func_w = wdata_i[FUNC_LO +: FUNC_W];
  assign go_w   = wdata_i[GO_BIT];
  assign wr_w   = wdata_i[WR_BIT];
  assign ok_w   = (func_w == FUNC_OSC) && (32'(dev_w) < N_OSC);
  assign idx_w  = IW'(dev_w);

  always_comb begin
    sel_osc = '0;
    for (int i = 0; i < N_OSC; i++)
      if (32'(idx_w) == i) sel_osc = osc_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_RST;
      stat_q <= '0;
      out_q  <= '0;
      rtn_q  <= '0;
    end else begin
      if (out_we_i) out_q <= wdata_i;
      if (cmd_we_i) begin
        cmd_q  <= wdata_i & CMD_KEEP;
        stat_q <= go_w ? {~ok_w, 1'b1} : 2'b00;
        if (go_w && !wr_w && ok_w) rtn_q <= sel_osc;
      end
    end
  end

  for (genvar g = 0; g < N_OSC; g++) begin : g_osc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) osc_q[g] <= OSC_RST[g];
      else if (cmd_we_i && go_w && wr_w && ok_w && 32'(idx_w) == g) osc_q[g] <= out_q;
    end
  end

  assign cmd_o  = cmd_q;
  assign stat_o = stat_q;
  assign out_o  = out_q;
  assign rtn_o  = rtn_q;

  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && !wdata_i[GO_BIT]) |=> (stat_o == 2'b00));
  a_r6_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && wdata_i[GO_BIT]) |=> stat_o[0]);
  a_r8_rtn_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && wdata_i[GO_BIT] && stat_o == 2'b00 && wdata_i[FUNC_LO +: FUNC_W] != FUNC_OSC)
      |=> $stable(rtn_o));
  a_r4_no_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i |=> !cmd_o[GO_BIT]);
endmodule

// File: rtl/sysctl_lock.sv
module sysctl_lock
  import sysctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [NLOOP-1:0] flags_i,
  output logic [DW-1:0]    rd_o
);
  logic [NLOOP-1:0] mask_q;
  logic all_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= MASK_RST;
    else if (we_i) mask_q <= wdata_i[DW-1 -: NLOOP];
  end

  assign all_ok = &(flags_i | ~mask_q);
  assign rd_o   = {mask_q, flags_i, 15'd0, all_ok};

  a_r9_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (rd_o[DW-1 -: NLOOP] == $past(wdata_i[DW-1 -: NLOOP])));
  a_r9_mask_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(rd_o[DW-1 -: NLOOP]));
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter logic [DW-1:0] CFG4_VAL = 32'h0000_0001,
  parameter logic [DW-1:0] AUX_ID   = 32'h0200_0008,
  parameter logic [DW-1:0] BLK_ID   = 32'h4104_0000,
  parameter int            N_OSC    = 3,
  parameter logic [N_OSC-1:0][DW-1:0] OSC_RST = {32'd25000000, 32'd24576000, 32'd50000000}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic [NLOOP-1:0] lock_flags_i,
  output logic [NLOOP-1:0] led_o,
  output logic             bad_access_o
);
  logic wr;
  logic [DW-1:0] cfg0_q, cfg1_q, cmd_w, out_w, rtn_w, lock_w;
  logic [1:0] stat_w;
  logic mapped, ro_hit, bad_q;

  assign wr = req_i && we_i;

  always_comb begin
    mapped = 1'b1;
    ro_hit = 1'b0;
    rdata_o = '0;
    unique case (addr_i)
      OFF_CFG0: rdata_o = cfg0_q;
      OFF_CFG1: rdata_o = cfg1_q;
      OFF_CFG3: ro_hit = 1'b1;
      OFF_CFG4: begin rdata_o = CFG4_VAL; ro_hit = 1'b1; end
      OFF_RTN:  begin rdata_o = rtn_w;    ro_hit = 1'b1; end
      OFF_OUT:  rdata_o = out_w;
      OFF_CMD:  rdata_o = cmd_w;
      OFF_STAT: begin rdata_o = {30'd0, stat_w}; ro_hit = 1'b1; end
      OFF_LOCK: rdata_o = lock_w;
      OFF_AUX:  begin rdata_o = AUX_ID;   ro_hit = 1'b1; end
      OFF_ID:   begin rdata_o = BLK_ID;   ro_hit = 1'b1; end
      default:  mapped = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg0_q <= '0;
      cfg1_q <= '0;
      bad_q  <= 1'b0;
    end else begin
      if (wr && addr_i == OFF_CFG0) cfg0_q <= wdata_i;
      if (wr && addr_i == OFF_CFG1) cfg1_q <= wdata_i;
      bad_q <= req_i && (!mapped || (we_i && ro_hit));
    end
  end

  sysctl_chan #(.N_OSC(N_OSC), .OSC_RST(OSC_RST)) u_chan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_we_i (wr && addr_i == OFF_CMD),
    .out_we_i (wr && addr_i == OFF_OUT),
    .wdata_i  (wdata_i),
    .cmd_o    (cmd_w),
    .stat_o   (stat_w),
    .out_o    (out_w),
    .rtn_o    (rtn_w)
  );

  sysctl_lock u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr && addr_i == OFF_LOCK),
    .wdata_i (wdata_i),
    .flags_i (lock_flags_i),
    .rd_o    (lock_w)
  );

  assign led_o        = cfg1_q[NLOOP-1:0];
  assign bad_access_o = bad_q;

  a_r2_led: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFF_CFG1) |=> (led_o == $past(wdata_i[NLOOP-1:0])));
  a_r10_bad_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i == 12'h008) |=> bad_access_o);
  a_r10_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !bad_access_o);
endmodule

// File: tb/tb_sysctl_regs.sv
`timescale 1ns/1ps
module tb_sysctl_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [7:0] flags = 8'hFF, led;
  logic bad_acc;
  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  sysctl_regs #(.CFG4_VAL(32'h0000_0001), .AUX_ID(32'h0200_0008), .BLK_ID(32'h4104_0000)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .lock_flags_i(flags), .led_o(led), .bad_access_o(bad_acc));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: compare read data against the scoreboard
  always @(negedge clk) begin
    if (req && !we) begin
      if (exp_q.size() == 0) chk(32'hDEAD, 32'h0, "scoreboard empty");
      else chk(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_reg(input logic [11:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    req = 1'b1; we = 1'b0; addr = a;
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  initial begin
    #50000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk({24'd0, led}, 32'h0, "R1 led");
    rd_reg(12'h000, 32'h0, "R1 cfg0");
    rd_reg(12'h004, 32'h0, "R1 cfg1");
    rd_reg(12'h0A8, 32'h0010_0000, "R1 cmd");
    rd_reg(12'h0AC, 32'h0, "R1 stat");
    rd_reg(12'h100, 32'hFFFF_0001, "R1 lock");
    rd_reg(12'h0A0, 32'h0, "R1 rtn");
    rd_reg(12'h0A4, 32'h0, "R1 out");
    chk({31'd0, bad_acc}, 32'h0, "R1 bad_access");
    // R2
    wr_reg(12'h000, 32'hA5A5_1234);
    rd_reg(12'h000, 32'hA5A5_1234, "R2 cfg0");
    wr_reg(12'h004, 32'h1234_56C3);
    chk({24'd0, led}, 32'hC3, "R2 led");
    rd_reg(12'h004, 32'h1234_56C3, "R2 cfg1");
    // R3
    rd_reg(12'h010, 32'h0000_0001, "R3 cfg4");
    rd_reg(12'hFF8, 32'h0200_0008, "R3 aux");
    rd_reg(12'hFFC, 32'h4104_0000, "R3 id");
    wr_reg(12'h00C, 32'hFFFF_FFFF);
    chk({31'd0, bad_acc}, 32'h1, "R10 ro write pulse");
    rd_reg(12'h00C, 32'h0, "R3 cfg3");
    wr_reg(12'h010, 32'hFFFF_FFFF);
    rd_reg(12'h010, 32'h0000_0001, "R3 cfg4 after write");
    wr_reg(12'hFFC, 32'h0);
    rd_reg(12'hFFC, 32'h4104_0000, "R3 id after write");
    // R4 masking, plus failed write (R8)
    wr_reg(12'h0A4, 32'h7777_7777);
    wr_reg(12'h0A8, 32'hFFFF_FFFF);
    chk({31'd0, bad_acc}, 32'h0, "R10 no pulse on cmd");
    rd_reg(12'h0A8, 32'h43F0_0FFF, "R4 cmd masked");
    rd_reg(12'h0AC, 32'h3, "R6 bad function error");
    // R5
    wr_reg(12'h0A8, 32'h0010_0000);
    rd_reg(12'h0AC, 32'h0, "R5 status cleared");
    // R7 write dev2 then read back
    wr_reg(12'h0A4, 32'h1111_2222);
    wr_reg(12'h0A8, 32'hC010_0002);
    rd_reg(12'h0AC, 32'h1, "R6 valid write done");
    wr_reg(12'h0A8, 32'h8010_0002);
    rd_reg(12'h0AC, 32'h1, "R6 valid read done");
    rd_reg(12'h0A0, 32'h1111_2222, "R7 osc2 written");
    wr_reg(12'h0A8, 32'h8010_0000);
    rd_reg(12'h0A0, 32'd50000000, "R8 osc0 untouched");
    wr_reg(12'h0A8, 32'h8010_0001);
    rd_reg(12'h0A0, 32'd24576000, "R7 osc1 read");
    // R8 failed reads
    wr_reg(12'h0A8, 32'h8010_0003);
    rd_reg(12'h0AC, 32'h3, "R6 device 3 error");
    rd_reg(12'h0A0, 32'd24576000, "R8 rtn kept dev3");
    wr_reg(12'h0A8, 32'h8020_0000);
    rd_reg(12'h0AC, 32'h3, "R6 function 2 error");
    rd_reg(12'h0A0, 32'd24576000, "R8 rtn kept func2");
    // R9 lock
    wr_reg(12'h100, 32'h0000_FFFF);
    rd_reg(12'h100, 32'h00FF_0001, "R9 mask zero");
    @(posedge clk); #1 flags = 8'h0F;
    wr_reg(12'h100, 32'h0F00_0000);
    rd_reg(12'h100, 32'h0F0F_0001, "R9 masked all set");
    wr_reg(12'h100, 32'h1F00_0000);
    rd_reg(12'h100, 32'h1F0F_0000, "R9 masked flag low");
    @(posedge clk); #1 flags = 8'h00;
    wr_reg(12'h100, 32'h0000_0000);
    rd_reg(12'h100, 32'h0000_0001, "R9 empty mask");
    // R10
    rd_reg(12'h008, 32'h0, "R10 unmapped read");
    chk({31'd0, bad_acc}, 32'h1, "R10 read pulse");
    @(posedge clk); #1;
    chk({31'd0, bad_acc}, 32'h0, "R10 pulse one cycle");
    wr_reg(12'h200, 32'hFFFF_FFFF);
    chk({31'd0, bad_acc}, 32'h1, "R10 unmapped write pulse");
    rd_reg(12'h000, 32'hA5A5_1234, "R10 cfg0 untouched");
    rd_reg(12'h004, 32'h1234_56C3, "R10 cfg1 untouched");
    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) chk(32'(exp_q.size()), 32'h0, "scoreboard leftover");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule